// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches an SDRAM command bus without driving it. On each rising clock edge it samples the clock enable, the four command strobes, the bank select and address bit 10. It decodes the command and keeps a state and a set of countdown timers for every bank. When a command breaks a state rule or a minimum spacing, it raises an error with a code for the broken rule and the bank involved.

The monitor is meant for self-checking testbenches and for debug probes inside a system. Every spacing limit is a parameter counted in whole clock cycles. The integrator converts each nanosecond figure by rounding it up to the next cycle at the clock rate in use. The burst length is also a parameter. It sets when a write's last data beat lands and when an auto-precharged bank becomes free again.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When `cke` is high and `cs_n` is low, the monitor decodes {`ras_n`,`cas_n`,`we_n`} as follows. 011 is activate. 010 is precharge, and `a10`=1 makes it apply to every bank. 101 is read and 100 is write, and `a10`=1 adds auto-precharge. 000 is mode-register load. 001 is refresh. 110 is burst stop, which has no effect. 111 is no-op. `cs_n` high is deselect.
- R2: After a reset cycle, `err_valid` is 0. A command sampled on edge k is judged on that same edge, and the result shows on `err_valid`/`err_code`/`err_bank` until edge k+1. When several rules fail together, the lowest code wins, and among banks the lowest bank number wins.
- R3: An activate to a bank that is open, or that is still finishing an auto-precharge, gives code 1.
- R4: An activate fewer than T_RP cycles after that bank's precharge gives code 2. A precharge to a bank that is already closed changes nothing.
- R5: Two activates to the same bank fewer than T_RC cycles apart give code 3.
- R6: Two activates to any banks fewer than T_RRD cycles apart give code 4.
- R7: An activate fewer than T_MRD cycles after a mode-register load gives code 5.
- R8: A read or write to a bank that is not open gives code 6. Column commands on consecutive cycles to an open bank give no error.
- R9: A read or write fewer than T_RCD cycles after that bank's activate gives code 7.
- R10: A precharge fewer than T_RAS_MIN cycles after the activate gives code 8. A bank left open for T_RAS_MAX+1 cycles raises code 10, once, on that cycle.
- R11: A precharge fewer than BURST+T_WR-1 cycles after a write to that bank gives code 9. The write's last data beat falls at write+BURST-1.
- R12: A refresh or mode-register load while any bank is open, auto-precharging or inside its T_RP window gives code 11, reported against the lowest such bank.
- R13: After a read with auto-precharge, the bank accepts an activate from BURST+T_RP cycles on. After a write with auto-precharge, it accepts one from BURST-1+T_WR+T_RP cycles on. Until then the bank counts as not open for column commands.
- R14: A cycle sampled with `cke` low is treated as no command, so no error is raised and no bank state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Sampled clock enable |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | All-banks / auto-precharge flag |
| err_valid | output | 1 | A rule was broken on the last edge |
| err_code | output | 4 | Code of the broken rule (1..11) |
| err_bank | output | BA_W | Bank the error refers to |

## Verification
The bench builds the monitor with shrunken limits: T_RCD=2, T_RP=2, T_RAS_MIN=4, T_RAS_MAX=20, T_RC=7, T_RRD=3, T_WR=2, T_MRD=3 and BURST=4. With these values every spacing can be swept from one cycle below its limit up to the limit itself in only a few cycles. The row-open timeout fits well inside a short run. T_RC is one cycle longer than T_RAS_MIN+T_RP, so a fast re-activate can break the precharge spacing and the row-cycle spacing separately or together, which exercises the priority order.

// File: rtl/sdram_mon_pkg.sv
// Package shared by the SDRAM command monitor: decoded command kinds and
// the numeric error codes. Codes are ordered by reporting priority (lower
// value wins when several rules fail on one edge).
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ACT,
        CMD_PRE,
        CMD_RD,
        CMD_WR,
        CMD_MRS,
        CMD_REF,
        CMD_BST
    } cmd_e;

    localparam int NUM_CODES     = 12;
    localparam int ERR_ACT_OPEN  = 1;
    localparam int ERR_ACT_RP    = 2;
    localparam int ERR_ACT_RC    = 3;
    localparam int ERR_ACT_RRD   = 4;
    localparam int ERR_ACT_MRD   = 5;
    localparam int ERR_COL_SHUT  = 6;
    localparam int ERR_COL_RCD   = 7;
    localparam int ERR_PRE_RAS   = 8;
    localparam int ERR_PRE_WR    = 9;
    localparam int ERR_RAS_LATE  = 10;
    localparam int ERR_NOT_IDLE  = 11;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: turns the sampled strobes into one command kind.
// Assumes strobes are active low. A cycle with clock enable low (suspend or
// power-down) or with chip select high decodes as CMD_NONE.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe pattern to a command kind
    always_comb begin
        cmd = CMD_NONE;
        if (cke && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
// Per-bank tracker: holds one bank's state (closed, open, auto-precharging)
// and down-counters for its own spacing rules. Each counter is loaded with
// (limit - 1) on the starting command, so a value of zero on a later cycle
// means the limit has been met. Raises per-code flags for the current cycle.
// Assumes all limits are at least one cycle.
module sdram_bank_track
    import sdram_mon_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 13334,
    parameter int T_RC      = 8,
    parameter int T_WR      = 2,
    parameter int BURST     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_act,
    input  logic                 do_rd,
    input  logic                 do_wr,
    input  logic                 do_pre,
    input  logic                 ap,
    output logic [NUM_CODES-1:0] flag,
    output logic                 ready
);

    localparam int CW = $clog2(T_RAS_MAX + T_RC + BURST + T_WR + T_RP + 3);
    localparam logic [CW-1:0] AGE_LATE = CW'(T_RAS_MAX + 1);

    typedef enum logic [1:0] {B_IDLE, B_OPEN, B_AUTO} bstate_e;

    bstate_e       state;
    logic [CW-1:0] rcd_rem, ras_rem, rc_rem, rp_rem, wr_rem, ap_rem, age;

    function automatic logic [CW-1:0] down(input logic [CW-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

    // Advance counters and follow the bank state from the observed commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= B_IDLE;
            rcd_rem <= '0;
            ras_rem <= '0;
            rc_rem  <= '0;
            rp_rem  <= '0;
            wr_rem  <= '0;
            ap_rem  <= '0;
            age     <= '0;
        end else begin
            rcd_rem <= down(rcd_rem);
            ras_rem <= down(ras_rem);
            rc_rem  <= down(rc_rem);
            rp_rem  <= down(rp_rem);
            wr_rem  <= down(wr_rem);
            ap_rem  <= down(ap_rem);
            if (state == B_OPEN && age <= AGE_LATE)
                age <= age + 1'b1;
            if (state == B_AUTO && ap_rem == CW'(1))
                state <= B_IDLE;
            if (do_act) begin
                state   <= B_OPEN;
                rcd_rem <= CW'(T_RCD - 1);
                ras_rem <= CW'(T_RAS_MIN - 1);
                rc_rem  <= CW'(T_RC - 1);
                wr_rem  <= '0;
                age     <= CW'(1);
            end else if (do_pre && state == B_OPEN) begin
                state  <= B_IDLE;
                rp_rem <= CW'(T_RP - 1);
            end else if ((do_rd || do_wr) && state == B_OPEN) begin
                if (do_wr)
                    wr_rem <= CW'(BURST + T_WR - 2);
                if (ap) begin
                    state  <= B_AUTO;
                    ap_rem <= do_wr ? CW'(BURST + T_WR + T_RP - 2)
                                    : CW'(BURST + T_RP - 1);
                end
            end
        end
    end

    // Judge this cycle's command against the bank's state and timers
    always_comb begin
        flag = '0;
        if (do_act) begin
            if (state != B_IDLE)     flag[ERR_ACT_OPEN] = 1'b1;
            else if (rp_rem != '0)   flag[ERR_ACT_RP]   = 1'b1;
            if (rc_rem != '0)        flag[ERR_ACT_RC]   = 1'b1;
        end
        if (do_rd || do_wr) begin
            if (state != B_OPEN)     flag[ERR_COL_SHUT] = 1'b1;
            else if (rcd_rem != '0)  flag[ERR_COL_RCD]  = 1'b1;
        end
        if (do_pre && state == B_OPEN) begin
            if (ras_rem != '0)       flag[ERR_PRE_RAS]  = 1'b1;
            if (wr_rem != '0)        flag[ERR_PRE_WR]   = 1'b1;
        end
        if (state == B_OPEN && age == AGE_LATE)
            flag[ERR_RAS_LATE] = 1'b1;
    end

    // Bank may take a refresh or mode load
    assign ready = (state == B_IDLE) && (rp_rem == '0);

    // R13
    auto_no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == B_AUTO && !do_act) |=> (state != B_OPEN));

    // R10
    late_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag[ERR_RAS_LATE] |=> !flag[ERR_RAS_LATE]);

    if (T_RCD > 1) begin : g_rcd_chk
        // R9
        rcd_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(do_act) && $past(rst_n) && (do_rd || do_wr))
            |-> flag[ERR_COL_RCD]);
    end

    if (BURST + T_WR > 2) begin : g_wr_chk
        // R11
        wr_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(do_wr) && $past(state == B_OPEN) && !$past(ap) &&
             $past(rst_n) && do_pre && !do_act) |-> flag[ERR_PRE_WR]);
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
// SDRAM command timing checker (top). Decodes the sampled bus, routes each
// command to the bank trackers, applies the cross-bank rules (activate to
// activate, mode load to activate, all-idle for refresh and mode load) and
// registers a single prioritised error report per cycle. Purely passive.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 13334,
    parameter int T_RC      = 8,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int BURST     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            err_valid,
    output logic [3:0]      err_code,
    output logic [BA_W-1:0] err_bank
);

    localparam int NUM_BANKS = 1 << BA_W;
    localparam int XW = $clog2((T_RRD > T_MRD ? T_RRD : T_MRD) + 1);

    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] b_act, b_rd, b_wr, b_pre, b_ready;
    logic [NUM_CODES-1:0] b_flag   [NUM_BANKS];
    logic [NUM_CODES-1:0] all_flag [NUM_BANKS];
    logic [XW-1:0]        rrd_rem, mrd_rem;
    logic [3:0]           code_d;
    logic [BA_W-1:0]      bank_d;
    logic                 need_idle;

    sdram_cmd_decode i_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        assign b_act[gb] = (cmd == CMD_ACT) && (ba == BA_W'(gb));
        assign b_rd[gb]  = (cmd == CMD_RD)  && (ba == BA_W'(gb));
        assign b_wr[gb]  = (cmd == CMD_WR)  && (ba == BA_W'(gb));
        assign b_pre[gb] = (cmd == CMD_PRE) && (a10 || ba == BA_W'(gb));

        sdram_bank_track #(
            .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN),
            .T_RAS_MAX(T_RAS_MAX), .T_RC(T_RC), .T_WR(T_WR), .BURST(BURST)
        ) i_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .do_act (b_act[gb]),
            .do_rd  (b_rd[gb]),
            .do_wr  (b_wr[gb]),
            .do_pre (b_pre[gb]),
            .ap     (a10),
            .flag   (b_flag[gb]),
            .ready  (b_ready[gb])
        );
    end

    assign need_idle = (cmd == CMD_MRS) || (cmd == CMD_REF);

    // Cross-bank spacing counters (any activate, mode load)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_rem <= '0;
            mrd_rem <= '0;
        end else begin
            rrd_rem <= (rrd_rem != '0) ? rrd_rem - 1'b1 : rrd_rem;
            mrd_rem <= (mrd_rem != '0) ? mrd_rem - 1'b1 : mrd_rem;
            if (cmd == CMD_ACT) rrd_rem <= XW'(T_RRD - 1);
            if (cmd == CMD_MRS) mrd_rem <= XW'(T_MRD - 1);
        end
    end

    // Merge bank and cross-bank flags, then pick lowest code, lowest bank
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            all_flag[b] = b_flag[b];
            all_flag[b][ERR_ACT_RRD]  = b_act[b] && (rrd_rem != '0);
            all_flag[b][ERR_ACT_MRD]  = b_act[b] && (mrd_rem != '0);
            all_flag[b][ERR_NOT_IDLE] = need_idle && !b_ready[b];
        end
        code_d = '0;
        bank_d = '0;
        for (int c = NUM_CODES - 1; c >= 1; c--) begin
            for (int b = NUM_BANKS - 1; b >= 0; b--) begin
                if (all_flag[b][c]) begin
                    code_d = 4'(c);
                    bank_d = BA_W'(b);
                end
            end
        end
    end

    // Register the error report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= '0;
            err_bank  <= '0;
        end else begin
            err_valid <= (code_d != '0);
            err_code  <= code_d;
            err_bank  <= bank_d;
        end
    end

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != '0 && err_code < 4'(NUM_CODES)));

    if (T_RRD > 1) begin : g_rrd_chk
        // R6
        act_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd == CMD_ACT) && $past(cmd == CMD_ACT) && $past(rst_n))
            |=> err_valid);
    end

endmodule

// File: tb/test_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdram_cmd_monitor;

    localparam int T_RCD = 2, T_RP = 2, T_RAS_MIN = 4, T_RAS_MAX = 20;
    localparam int T_RC = 7, T_RRD = 3, T_WR = 2, T_MRD = 3, BURST = 4;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] P_ACT = 4'b0011, P_PRE = 4'b0010, P_RD = 4'b0101;
    localparam logic [3:0] P_WR = 4'b0100, P_MRS = 4'b0000, P_REF = 4'b0001;
    localparam logic [3:0] P_BST = 4'b0110, P_NOP = 4'b0111;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic a10 = 1'b0;
    logic err_valid;
    logic [3:0] err_code;
    logic [1:0] err_bank;
    int n_vec = 0, n_fail = 0;

    always #4 clk = ~clk;

    sdram_cmd_monitor #(
        .BA_W(2), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN),
        .T_RAS_MAX(T_RAS_MAX), .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR),
        .T_MRD(T_MRD), .BURST(BURST)
    ) i_sdram_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank)
    );

    task automatic chk(input int exp, input int eb, input string tag);
        n_vec++;
        if (err_valid !== (exp != 0) ||
            (exp != 0 && (err_code !== 4'(exp) || err_bank !== 2'(eb)))) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b code=%0d bank=%0d, expected code=%0d bank=%0d",
                     tag, err_valid, err_code, err_bank, exp, eb);
        end
    endtask

    // Drive one command for one cycle, then check the report
    task automatic step(input logic [3:0] p, input int b, input logic a,
                        input int exp, input int eb, input string tag);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba  = 2'(b);
        a10 = a;
        @(negedge clk);
        chk(exp, eb, tag);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) step(P_NOP, 0, 1'b0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(P_NOP, 0, 1'b0, 0, 0, "R2 reset");
        nops(2, "R2 idle");

        // R9: read spacing after activate, every bank
        for (int b = 0; b < 4; b++)
            for (int g = 1; g <= T_RCD + 1; g++) begin
                step(P_ACT, b, 1'b0, 0, 0, "R9 act");
                nops(g - 1, "R9 gap");
                step(P_RD, b, 1'b0, (g < T_RCD) ? 7 : 0, b, "R9 rd");
                nops(6, "R9 wait");
                step(P_PRE, b, 1'b0, 0, 0, "R9 pre");
                nops(10, "R9 settle");
            end

        // R10: minimum row open time
        for (int b = 0; b < 4; b++)
            for (int g = 1; g <= T_RAS_MIN + 1; g++) begin
                step(P_ACT, b, 1'b0, 0, 0, "R10 act");
                nops(g - 1, "R10 gap");
                step(P_PRE, b, 1'b0, (g < T_RAS_MIN) ? 8 : 0, b, "R10 pre");
                nops(10, "R10 settle");
            end

        // R11: write recovery before precharge
        for (int h = 1; h <= BURST + T_WR; h++) begin
            step(P_ACT, h % 4, 1'b0, 0, 0, "R11 act");
            nops(3, "R11 gap");
            step(P_WR, h % 4, 1'b0, 0, 0, "R11 wr");
            nops(h - 1, "R11 gap");
            step(P_PRE, h % 4, 1'b0, (h < BURST + T_WR - 1) ? 9 : 0, h % 4, "R11 pre");
            nops(10, "R11 settle");
        end

        // R4 R5 R2: precharge and row cycle spacing, priority 2 over 3
        for (int q = 1; q <= 3; q++) begin
            step(P_ACT, 2, 1'b0, 0, 0, "R5 act");
            nops(T_RAS_MIN - 1, "R5 gap");
            step(P_PRE, 2, 1'b0, 0, 0, "R4 pre");
            nops(q - 1, "R4 gap");
            step(P_ACT, 2, 1'b0,
                 (q < T_RP) ? 2 : ((T_RAS_MIN + q < T_RC) ? 3 : 0), 2, "R2 R4 R5 act");
            nops(4, "R5 gap");
            step(P_PRE, 2, 1'b0, 0, 0, "R5 pre");
            nops(10, "R5 settle");
        end
        // R4: precharge to a closed bank has no effect
        step(P_PRE, 1, 1'b0, 0, 0, "R4 idle pre");
        step(P_ACT, 1, 1'b0, 0, 0, "R4 act after idle pre");
        nops(4, "R4 gap");
        step(P_PRE, 1, 1'b0, 0, 0, "R4 pre");
        nops(10, "R4 settle");

        // R6: activate to activate across banks
        for (int g = 1; g <= T_RRD; g++) begin
            step(P_ACT, 0, 1'b0, 0, 0, "R6 act0");
            nops(g - 1, "R6 gap");
            step(P_ACT, 1, 1'b0, (g < T_RRD) ? 4 : 0, 1, "R6 act1");
            nops(5, "R6 gap");
            step(P_PRE, 0, 1'b1, 0, 0, "R6 pre all");
            nops(10, "R6 settle");
        end

        // R7: mode load to activate
        for (int g = 1; g <= T_MRD; g++) begin
            step(P_MRS, 0, 1'b0, 0, 0, "R1 R7 mrs");
            nops(g - 1, "R7 gap");
            step(P_ACT, 3, 1'b0, (g < T_MRD) ? 5 : 0, 3, "R7 act");
            nops(4, "R7 gap");
            step(P_PRE, 3, 1'b0, 0, 0, "R7 pre");
            nops(10, "R7 settle");
        end

        // R12: refresh / mode load need every bank ready
        step(P_ACT, 2, 1'b0, 0, 0, "R12 act");
        nops(4, "R12 gap");
        step(P_REF, 0, 1'b0, 11, 2, "R12 ref open");
        step(P_MRS, 0, 1'b0, 11, 2, "R12 mrs open");
        step(P_PRE, 0, 1'b1, 0, 0, "R12 pre all");
        step(P_REF, 0, 1'b0, 11, 2, "R12 ref in rp");
        step(P_REF, 0, 1'b0, 0, 0, "R12 ref ok");
        nops(10, "R12 settle");
        step(P_ACT, 3, 1'b0, 0, 0, "R12 act3");
        nops(2, "R12 gap");
        step(P_ACT, 1, 1'b0, 0, 0, "R12 act1");
        nops(4, "R12 gap");
        step(P_REF, 0, 1'b0, 11, 1, "R12 lowest bank");
        step(P_PRE, 0, 1'b1, 0, 0, "R12 pre all");
        nops(10, "R12 settle");

        // R8: column commands to closed banks, and back-to-back to open
        step(P_RD, 0, 1'b0, 6, 0, "R8 rd closed");
        step(P_WR, 3, 1'b0, 6, 3, "R8 wr closed");
        step(P_ACT, 1, 1'b0, 0, 0, "R8 act");
        nops(1, "R8 gap");
        step(P_RD, 1, 1'b0, 0, 0, "R8 rd");
        step(P_RD, 1, 1'b0, 0, 0, "R8 rd");
        step(P_WR, 1, 1'b0, 0, 0, "R8 wr");
        step(P_RD, 1, 1'b0, 0, 0, "R8 rd");
        step(P_BST, 1, 1'b0, 0, 0, "R1 bst");
        nops(5, "R8 gap");
        step(P_PRE, 1, 1'b0, 0, 0, "R8 pre");
        nops(10, "R8 settle");

        // R3: activate to an open bank
        step(P_ACT, 0, 1'b0, 0, 0, "R3 act");
        nops(7, "R3 gap");
        step(P_ACT, 0, 1'b0, 1, 0, "R1 R3 reopen");
        nops(4, "R3 gap");
        step(P_PRE, 0, 1'b0, 0, 0, "R3 pre");
        nops(10, "R3 settle");

        // R14: cycles with clock enable low are ignored
        cke = 1'b0;
        step(P_RD, 2, 1'b0, 0, 0, "R14 rd ignored");
        step(P_ACT, 2, 1'b0, 0, 0, "R14 act ignored");
        cke = 1'b1;
        step(P_RD, 2, 1'b0, 6, 2, "R14 bank still closed");
        nops(3, "R14 settle");

        // R13: auto-precharge after read
        for (int k = BURST + T_RP - 1; k <= BURST + T_RP; k++) begin
            step(P_ACT, 1, 1'b0, 0, 0, "R13 act");
            nops(1, "R13 gap");
            step(P_RD, 1, 1'b1, 0, 0, "R13 rd ap");
            nops(k - 1, "R13 gap");
            step(P_ACT, 1, 1'b0, (k < BURST + T_RP) ? 1 : 0, 1, "R13 act after rd ap");
            nops(4, "R13 gap");
            step(P_PRE, 1, 1'b0, 0, 0, "R13 pre");
            nops(10, "R13 settle");
        end
        // R13: auto-precharge after write, and column access while closing
        for (int k = BURST + T_WR + T_RP - 2; k <= BURST + T_WR + T_RP - 1; k++) begin
            step(P_ACT, 0, 1'b0, 0, 0, "R13 act");
            nops(1, "R13 gap");
            step(P_WR, 0, 1'b1, 0, 0, "R13 wr ap");
            step(P_RD, 0, 1'b0, 6, 0, "R13 rd while closing");
            nops(k - 2, "R13 gap");
            step(P_ACT, 0, 1'b0, (k < BURST + T_WR + T_RP - 1) ? 1 : 0, 0,
                 "R13 act after wr ap");
            nops(4, "R13 gap");
            step(P_PRE, 0, 1'b0, 0, 0, "R13 pre");
            nops(10, "R13 settle");
        end

        // R10: row left open too long, reported once
        step(P_ACT, 3, 1'b0, 0, 0, "R10 act");
        for (int i = 1; i <= T_RAS_MAX + 5; i++)
            step(P_NOP, 0, 1'b0, (i == T_RAS_MAX + 1) ? 10 : 0, 3, "R10 late");
        step(P_PRE, 3, 1'b0, 0, 0, "R10 late pre");
        nops(5, "R10 settle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule